// File: doc/BRIEF.md
# ADC Reference and Result Register Front End

This block is the register-side front end of a 10-bit successive-approximation converter. It holds one control register. That register carries three fields: the voltage reference to use, whether the result is aligned to the left, and the input channel to convert. It also has a small auxiliary register. That register holds a capacitor-present control bit and a sticky error flag for reserved reference codes. Software reaches the block over a simple synchronous bus: writes take effect on the clock edge, and reads are combinational from the address.

The converter itself sits outside the block. It reports that a conversion is in progress with a busy level, and it pulses a done flag together with its 10-bit result. The front end protects the analog side from mid-conversion changes:

- A reference selection written while a conversion is running goes into a shadow register. It only becomes active on the edge where done is seen.
- The channel given to the converter is frozen for as long as busy is high.
- The alignment bit is different: it re-formats the two readable result bytes at once, even when a conversion is in progress.

The active reference is decoded into separate enables for the analog side: external pin, analog supply, internal 2.56 V reference, and reference-pin capacitor. The internal reference enable follows the active selection directly. It does not wait for a conversion to start.

Top module: `adc_ctl_front`

## Requirements
- R1: Address 0 is the control register, with reference select in bits 7:6, left-align flag in bit 5 and channel in bits 4:0. Every bit reads back as last written, and the register resets to 0x00. Address 3 holds the capacitor-present bit in bit 0 and the error flag in bit 1, and resets to 0x00.
- R2: While busy is low, a written reference code other than 10 becomes the active reference on the write edge itself.
- R3: A reference code written while busy is high leaves the active reference unchanged until the edge on which done is high. On that edge the last written code becomes active.
- R4: Address 1 is the high result byte and address 2 is the low result byte.
  - With left align set, the high byte holds result bits 9:2 and low-byte bits 7:6 hold result bits 1:0.
  - With left align clear, high-byte bits 1:0 hold result bits 9:8 and the low byte holds bits 7:0.
  - All other bits read 0.
- R5: A write of the left-align flag re-formats addresses 1 and 2 from the write edge on, including during a conversion.
- R6: The active reference is decoded as follows:
  - Code 00 asserts only refExtSel.
  - Code 01 asserts only refSupplySel.
  - Code 11 asserts only refIntEn.
  - refCapEn equals the capacitor-present bit when the active code is 01 or 11, and is 0 for code 00.
- R7: refIntEn is high whenever the active code is 11, with no conversion required.
- R8: Writing code 10 leaves the active reference as it was and sets the error flag (address 3 bit 1). The flag stays set until a write to address 3 with bit 1 equal to 1.
- R9: convChannel follows the channel field while busy is low, and holds its value for as long as busy is high.
- R10: The converter result is captured on every edge on which done is high, and only on those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address (0 control, 1 high byte, 2 low byte, 3 auxiliary) |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the addressed register |
| convBusy | input | 1 | Converter is running a conversion |
| convDone | input | 1 | Converter result is valid on this cycle |
| convResult | input | 10 | Converter result |
| convChannel | output | 5 | Channel presented to the converter |
| refExtSel | output | 1 | External reference pin selected |
| refSupplySel | output | 1 | Analog supply selected as reference |
| refIntEn | output | 1 | Internal 2.56 V reference enabled |
| refCapEn | output | 1 | Capacitor on reference pin in use |

## Verification
The bench writes a new reference code in the middle of a conversion. A design that committed the shadow too early would show the new enable before done. The bench also flips the alignment flag during a conversion. A design that re-formatted only when a new result arrives would keep returning the old byte layout. The reserved code 10 is written both while idle and while busy. A design without the guard would drop every enable or corrupt the decode, and one without the sticky flag would read the error bit back as 0. Writing the channel during a conversion catches a design whose converter channel slips mid-conversion.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef struct packed {
    logic ctlWr;
    logic auxWr;
    logic refCommit;
    logic chanTrack;
    logic resLatch;
    logic errSet;
    logic errClr;
  } adcStrobe_t;

  typedef enum logic [1:0] {
    ADDR_CTL = 2'd0,
    ADDR_HI  = 2'd1,
    ADDR_LO  = 2'd2,
    ADDR_AUX = 2'd3
  } adcAddr_e;

  localparam logic [1:0] REF_EXT    = 2'b00;
  localparam logic [1:0] REF_SUPPLY = 2'b01;
  localparam logic [1:0] REF_RSVD   = 2'b10;
  localparam logic [1:0] REF_INT    = 2'b11;

endpackage

// File: rtl/adc_ctl_ctrl.sv
module adc_ctl_ctrl
  import adc_ctl_pkg::*;
(
  input  logic       busWrEn,
  input  logic [1:0] busAddr,
  input  logic [1:0] wrRefField,
  input  logic       wrClrBit,
  input  logic       convBusy,
  input  logic       convDone,
  output adcStrobe_t stb
);

  always_comb begin
    stb.ctlWr     = busWrEn && (adcAddr_e'(busAddr) == ADDR_CTL);
    stb.auxWr     = busWrEn && (adcAddr_e'(busAddr) == ADDR_AUX);
    // reference may move when idle, or on the completion edge
    stb.refCommit = !convBusy || convDone;
    // channel is frozen for the whole conversion
    stb.chanTrack = !convBusy;
    stb.resLatch  = convDone;
    stb.errSet    = stb.ctlWr && (wrRefField == REF_RSVD);
    stb.errClr    = stb.auxWr && wrClrBit;
  end

endmodule

// File: rtl/adc_ctl_data.sv
module adc_ctl_data
  import adc_ctl_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  adcStrobe_t          stb,
  input  logic [1:0]          busAddr,
  input  logic [CHAN_W+2:0]   busWrData,
  input  logic [RES_W-1:0]    convResult,
  output logic [CHAN_W+2:0]   busRdData,
  output logic [CHAN_W-1:0]   convChannel,
  output logic                refExtSel,
  output logic                refSupplySel,
  output logic                refIntEn,
  output logic                refCapEn,
  output logic                errFlag
);

  localparam int DATA_W = CHAN_W + 3;
  localparam int PACK_W = 2 * DATA_W;
  localparam int PAD_W  = PACK_W - RES_W;

  logic [1:0]        shadowRef;
  logic [1:0]        activeRef;
  logic              leftAdj;
  logic [CHAN_W-1:0] chanReg;
  logic [CHAN_W-1:0] chanActive;
  logic              capPresent;
  logic              refErr;
  logic [RES_W-1:0]  resultReg;

  logic [1:0]        nextRef;
  logic [CHAN_W-1:0] nextChan;
  logic [PACK_W-1:0] packed16;

  always_comb begin
    nextRef  = stb.ctlWr ? busWrData[DATA_W-1 -: 2] : shadowRef;
    nextChan = stb.ctlWr ? busWrData[CHAN_W-1:0]    : chanReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowRef  <= REF_EXT;
      activeRef  <= REF_EXT;
      leftAdj    <= 1'b0;
      chanReg    <= '0;
      chanActive <= '0;
      capPresent <= 1'b0;
      refErr     <= 1'b0;
      resultReg  <= '0;
    end else begin
      if (stb.ctlWr) begin
        shadowRef <= busWrData[DATA_W-1 -: 2];
        leftAdj   <= busWrData[CHAN_W];
        chanReg   <= busWrData[CHAN_W-1:0];
      end
      if (stb.auxWr) capPresent <= busWrData[0];
      if (stb.errSet)      refErr <= 1'b1;
      else if (stb.errClr) refErr <= 1'b0;
      if (stb.refCommit && (nextRef != REF_RSVD)) activeRef <= nextRef;
      if (stb.chanTrack) chanActive <= nextChan;
      if (stb.resLatch)  resultReg  <= convResult;
    end
  end

  // alignment is applied on the read path, so it acts at once
  always_comb begin
    if (leftAdj) packed16 = {resultReg, {PAD_W{1'b0}}};
    else         packed16 = {{PAD_W{1'b0}}, resultReg};
  end

  always_comb begin
    case (adcAddr_e'(busAddr))
      ADDR_CTL: busRdData = {shadowRef, leftAdj, chanReg};
      ADDR_HI:  busRdData = packed16[PACK_W-1:DATA_W];
      ADDR_LO:  busRdData = packed16[DATA_W-1:0];
      default:  busRdData = {{(DATA_W-2){1'b0}}, refErr, capPresent};
    endcase
  end

  always_comb begin
    refExtSel    = (activeRef == REF_EXT);
    refSupplySel = (activeRef == REF_SUPPLY);
    refIntEn     = (activeRef == REF_INT);
    refCapEn     = capPresent && (activeRef != REF_EXT);
  end

  assign convChannel = chanActive;
  assign errFlag     = refErr;

endmodule

// File: rtl/adc_ctl_front.sv
module adc_ctl_front
  import adc_ctl_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWrEn,
  input  logic [CHAN_W+2:0]   busWrData,
  output logic [CHAN_W+2:0]   busRdData,
  input  logic                convBusy,
  input  logic                convDone,
  input  logic [RES_W-1:0]    convResult,
  output logic [CHAN_W-1:0]   convChannel,
  output logic                refExtSel,
  output logic                refSupplySel,
  output logic                refIntEn,
  output logic                refCapEn
);

  localparam int DATA_W = CHAN_W + 3;

  adcStrobe_t stb;
  logic       errFlag;

  adc_ctl_ctrl u_ctrl (
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .wrRefField (busWrData[DATA_W-1 -: 2]),
    .wrClrBit   (busWrData[1]),
    .convBusy   (convBusy),
    .convDone   (convDone),
    .stb        (stb)
  );

  adc_ctl_data #(.RES_W(RES_W), .CHAN_W(CHAN_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .busAddr      (busAddr),
    .busWrData    (busWrData),
    .convResult   (convResult),
    .busRdData    (busRdData),
    .convChannel  (convChannel),
    .refExtSel    (refExtSel),
    .refSupplySel (refSupplySel),
    .refIntEn     (refIntEn),
    .refCapEn     (refCapEn),
    .errFlag      (errFlag)
  );

endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic              busWrEn,
  input logic [CHAN_W+2:0] busWrData,
  input logic              convBusy,
  input logic              convDone,
  input logic [CHAN_W-1:0] convChannel,
  input logic              refExtSel,
  input logic              refSupplySel,
  input logic              refIntEn,
  input logic              refCapEn,
  input logic              errFlag
);

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && !convDone) |=> $stable({refExtSel, refSupplySel, refIntEn}));

  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |=> $stable(convChannel));

  // R6
  ref_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({refExtSel, refSupplySel, refIntEn}) == 1);

  // R6
  cap_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    refCapEn |-> !refExtSel);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(busWrEn && busAddr == 2'd3 && busWrData[1])) |=> errFlag);

endmodule

bind adc_ctl_front adc_ctl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .busWrEn      (busWrEn),
  .busWrData    (busWrData),
  .convBusy     (convBusy),
  .convDone     (convDone),
  .convChannel  (convChannel),
  .refExtSel    (refExtSel),
  .refSupplySel (refSupplySel),
  .refIntEn     (refIntEn),
  .refCapEn     (refCapEn),
  .errFlag      (errFlag)
);

// File: tb/adc_ctl_front_tb.sv
`timescale 1ns/1ps
module adc_ctl_front_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       convBusy = 1'b0;
  logic       convDone = 1'b0;
  logic [9:0] convResult = 10'h000;
  logic [4:0] convChannel;
  logic       refExtSel, refSupplySel, refIntEn, refCapEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         rdReq = 1'b0;

  always #4 clk = ~clk;

  adc_ctl_front u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .convBusy(convBusy),
    .convDone(convDone), .convResult(convResult), .convChannel(convChannel),
    .refExtSel(refExtSel), .refSupplySel(refSupplySel), .refIntEn(refIntEn),
    .refCapEn(refCapEn)
  );

  // monitor: pops expected reads and compares
  always @(negedge clk) begin
    if (rdReq) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (busRdData !== e) begin
        nFails++;
        $display("FAIL %s read addr %0d: got %02h expected %02h", t, busAddr, busRdData, e);
      end
      rdReq = 1'b0;
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [1:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    rdReq = 1'b1;
    wait (!rdReq);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", t, act, e);
    end
  endtask

  task automatic startConv();
    @(posedge clk); #1;
    convBusy = 1'b1;
  endtask

  task automatic finishConv(input logic [9:0] r);
    @(posedge clk); #1;
    convDone = 1'b1; convResult = r;
    @(posedge clk); #1;
    convDone = 1'b0; convBusy = 1'b0;
  endtask

  task automatic refState(input logic [2:0] e, input string t);
    @(negedge clk);
    chk({5'b0, refExtSel, refSupplySel, refIntEn}, {5'b0, e}, t);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    rdExp(2'd0, 8'h00, "R1 reset ctl");
    rdExp(2'd3, 8'h00, "R1 reset aux");
    refState(3'b100, "R6 reset ext");

    // idle write: internal ref, channel 5
    wrReg(2'd0, 8'hC5);
    rdExp(2'd0, 8'hC5, "R1 readback");
    refState(3'b001, "R2 idle commit");
    refState(3'b001, "R7 int enabled without conversion");
    @(negedge clk); chk({3'b0, convChannel}, 8'h05, "R9 idle track");
    wrReg(2'd3, 8'h01);
    @(negedge clk); chk({7'b0, refCapEn}, 8'h01, "R6 cap with int");

    // write during conversion is held
    startConv();
    wrReg(2'd0, 8'h4A);
    refState(3'b001, "R3 held while busy");
    @(negedge clk); chk({3'b0, convChannel}, 8'h05, "R9 frozen");
    rdExp(2'd0, 8'h4A, "R1 shadow readback");
    wrReg(2'd0, 8'h6A);
    finishConv(10'h2A7);
    refState(3'b010, "R3 commit on done");
    @(negedge clk); chk({7'b0, refCapEn}, 8'h01, "R6 cap with supply");
    @(negedge clk); chk({3'b0, convChannel}, 8'h0A, "R9 track after done");
    rdExp(2'd1, 8'hA9, "R4 left high");
    rdExp(2'd2, 8'hC0, "R4 left low");

    // alignment change mid conversion acts at once
    startConv();
    wrReg(2'd0, 8'h4A);
    rdExp(2'd1, 8'h02, "R5 right high busy");
    rdExp(2'd2, 8'hA7, "R5 right low busy");
    wrReg(2'd0, 8'h6A);
    rdExp(2'd1, 8'hA9, "R5 left again busy");
    finishConv(10'h3FF);
    rdExp(2'd1, 8'hFF, "R10 new high");
    rdExp(2'd2, 8'hC0, "R10 new low");

    // reserved code while idle
    wrReg(2'd0, 8'h80);
    refState(3'b010, "R8 reserved keeps ref");
    rdExp(2'd3, 8'h03, "R8 flag set");
    rdExp(2'd0, 8'h80, "R1 reserved readback");
    wrReg(2'd0, 8'h00);
    rdExp(2'd3, 8'h03, "R8 flag sticky");
    wrReg(2'd3, 8'h03);
    rdExp(2'd3, 8'h01, "R8 flag cleared");
    refState(3'b100, "R2 ext selected");
    @(negedge clk); chk({7'b0, refCapEn}, 8'h00, "R6 no cap on ext");

    // reserved code during conversion
    startConv();
    wrReg(2'd0, 8'h80);
    finishConv(10'h155);
    refState(3'b100, "R8 reserved at done");
    rdExp(2'd1, 8'h01, "R10 right high");
    rdExp(2'd2, 8'h55, "R10 right low");

    // no done: result not captured
    @(posedge clk); #1 convResult = 10'h0F0;
    repeat (2) @(posedge clk);
    rdExp(2'd2, 8'h55, "R10 no capture without done");

    wrReg(2'd0, 8'hC0);
    refState(3'b001, "R7 int on idle select");
    wrReg(2'd3, 8'h00);
    @(negedge clk); chk({7'b0, refCapEn}, 8'h00, "R6 cap off");

    summary();
  end

endmodule